// File: doc/BRIEF.md
# Single-Cycle RISC Integer Core

This block is a small 32-bit processor core that completes one instruction in every clock cycle. On each rising edge it commits the effect of the instruction presented at the instruction port: the program counter, one register write and, for a store, the memory write that the data port carries during that cycle. Fetch, decode, register read, arithmetic, data access and writeback all take place in the combinational path between two edges.

Instructions and data use separate ports. The instruction port is an address output with a 32-bit word input. The data port has an address, write data, a write strobe, a read strobe and a read-data input. The caller's memories must answer combinationally within the same cycle. The 32-entry register file is internal. Register 0 always reads as zero.

The core decodes three instruction formats with fixed field positions. It implements eleven operations: add, exclusive-or, left shift by a constant, signed set-less-than, add-immediate in its wrapping and its non-trapping forms, signed set-less-than-immediate, word load, word store, branch-if-equal and absolute jump. Any other code is retired as a no-op.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 whatever instruction is presented. `dmem_we` stays low for as long as `rst` is high.
- R2: Any instruction that is not a taken branch or a jump advances the PC by 4 at the next edge.
- R3: Opcode bits [31:26] = 000000 selects the register format. The fields are rs = [25:21], rt = [20:16], rd = [15:11], shift = [10:6] and function = [5:0]. The function codes are: 100001 writes rd = rs + rt modulo 2^32; 100110 writes rd = rs ^ rt; 101010 writes rd = 1 if rs < rt as signed values, else 0; 000000 writes rd = rt << shift.
- R4: The immediate format uses imm = [15:0], sign-extended, and writes rt. Opcode 001001 and opcode 001000 both write rs + imm modulo 2^32; neither flags overflow. Opcode 001010 writes 1 if rs < imm as signed values, else 0.
- R5: Opcode 100011 (load) raises `dmem_re` with `dmem_addr` = rs + sext(imm) and writes `dmem_rdata` into rt at the edge. `dmem_we` and `dmem_re` are never high together.
- R6: Opcode 101011 (store) raises `dmem_we` with `dmem_addr` = rs + sext(imm) and `dmem_wdata` = rt, and writes no register. No other instruction raises `dmem_we`.
- R7: Opcode 000100 (branch) sets the next PC to PC + 4 + (sext(imm) << 2) when rs equals rt, and otherwise to PC + 4. It writes no register.
- R8: Opcode 000010 (jump) sets the next PC to {(PC+4)[31:28], instr[25:0], 2'b00}.
- R9: Register 0 reads as 0. Writes that target it are discarded.
- R10: Any opcode, or register-format function code, not listed above changes no register and raises no data strobe. The PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data for dmem_addr, same cycle |

## Verification
The bench runs the core in lockstep with its own instruction-level model and feeds it one instruction word per cycle. It compares the PC every cycle, and the data strobes, the address and the store data on every load and store. Register contents can only be seen through later stores and branch outcomes.

A directed prologue loads every register. It then builds the extreme values 0x80000000 and 0x7fffffff and applies wrapping adds and signed compares to them. These show whether the add is truly modulo 2^32 and whether the compares treat their operands as signed rather than unsigned. Directed taken and untaken branches, backward branches and jumps separate the three PC sources. Writes to register 0 and unknown codes test whether state is discarded correctly.

The random phase biases operand registers toward a small set so that results feed into later instructions. It also makes branch operands equal often, so that forwarding of results through the register file and the branch compare are both exercised.

// File: rtl/sc_core.sv
module sc_core #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          NREG     = 32
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic        dmem_re,
  input  logic [31:0] dmem_rdata
);
  localparam int RW = $clog2(NREG);

  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_JUMP  = 6'b000010;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_ADDIU = 6'b001001;
  localparam logic [5:0] OP_SLTI  = 6'b001010;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;

  localparam logic [5:0] FN_SHL  = 6'b000000;
  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_XOR  = 6'b100110;
  localparam logic [5:0] FN_SLT  = 6'b101010;

  logic [31:0] pc;
  logic [31:0] rf [NREG];

  wire [5:0]    op    = imem_data[31:26];
  wire [RW-1:0] rs    = imem_data[25:21];
  wire [RW-1:0] rt    = imem_data[20:16];
  wire [RW-1:0] rd    = imem_data[15:11];
  wire [4:0]    shamt = imem_data[10:6];
  wire [5:0]    fn    = imem_data[5:0];
  wire [31:0]   sext  = {{16{imem_data[15]}}, imem_data[15:0]};

  wire [31:0] rs_val = (rs == '0) ? 32'd0 : rf[rs];
  wire [31:0] rt_val = (rt == '0) ? 32'd0 : rf[rt];

  wire is_reg   = (op == OP_REG);
  wire is_addu  = is_reg && (fn == FN_ADDU);
  wire is_xor   = is_reg && (fn == FN_XOR);
  wire is_slt   = is_reg && (fn == FN_SLT);
  wire is_shl   = is_reg && (fn == FN_SHL);
  wire is_addi  = (op == OP_ADDI) || (op == OP_ADDIU);
  wire is_slti  = (op == OP_SLTI);
  wire is_load  = (op == OP_LOAD);
  wire is_store = (op == OP_STORE);
  wire is_beq   = (op == OP_BEQ);
  wire is_jump  = (op == OP_JUMP);

  wire reg_ok   = is_addu || is_xor || is_slt || is_shl;
  wire [31:0] opb = is_reg ? rt_val : sext;
  wire [31:0] sum = rs_val + opb;
  wire lt_s = $signed(rs_val) < $signed(opb);

  logic [31:0] alu;
  always_comb begin
    alu = sum;
    if (is_xor)               alu = rs_val ^ rt_val;
    else if (is_shl)          alu = rt_val << shamt;
    else if (is_slt || is_slti) alu = {31'd0, lt_s};
  end

  wire [RW-1:0] waddr   = is_reg ? rd : rt;
  wire          wr_kind = reg_ok || is_addi || is_slti || is_load;
  wire          rf_we   = !rst && wr_kind && (waddr != '0);
  wire [31:0]   wb_data = is_load ? dmem_rdata : alu;

  wire [31:0] pc_plus4  = pc + 32'd4;
  wire [31:0] br_target = pc_plus4 + {sext[29:0], 2'b00};
  wire [31:0] j_target  = {pc_plus4[31:28], imem_data[25:0], 2'b00};
  wire        take_br   = is_beq && (rs_val == rt_val);
  wire [31:0] pc_next   = is_jump ? j_target : (take_br ? br_target : pc_plus4);

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rf_we) rf[waddr] <= wb_data;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = sum;
  assign dmem_wdata = rt_val;
  assign dmem_we    = is_store && !rst;
  assign dmem_re    = is_load && !rst;

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> (pc == RESET_PC))
    else $error("reset did not load the PC");
  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (!take_br && !is_jump) |=> (pc == $past(pc) + 32'd4))
    else $error("sequential PC step wrong");
  p_branch_r7: assert property (@(posedge clk) disable iff (rst)
    take_br |=> (pc == $past(pc) + 32'd4 + {$past(sext[29:0]), 2'b00}))
    else $error("branch target wrong");
  p_jump_r8: assert property (@(posedge clk) disable iff (rst)
    is_jump |=> (pc[27:0] == {$past(imem_data[25:0]), 2'b00}))
    else $error("jump target wrong");
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dmem_we, dmem_re}))
    else $error("load and store strobes together");
  p_wb_commit_r9: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> (rf[$past(waddr)] == $past(wb_data)))
    else $error("register write not committed");
endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/100ps
module test_sc_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we, dmem_re;

  always #2.5 clk = ~clk;

  sc_core i_sc_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_pc;
  logic [31:0] m_reg [32];
  string       m_tag [32];
  string       pc_tag;
  logic        e_we, e_re;
  logic [31:0] e_addr, e_wdata;
  string       mem_tag, data_tag;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input int sh, input logic [5:0] f);
    return {6'b0, 5'(s), 5'(t), 5'(d), 5'(sh), f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] o, input int s, input int t, input logic [15:0] im);
    return {o, 5'(s), 5'(t), im};
  endfunction

  task automatic wr(input logic [4:0] d, input logic [31:0] v, input string t);
    if (d != 0) begin
      m_reg[d] = v;
      m_tag[d] = t;
    end
  endtask

  task automatic model(input logic [31:0] ins, input logic [31:0] rdata);
    logic [5:0] op; logic [4:0] s, t, d, sh; logic [5:0] f;
    logic [31:0] se, a, b, np;
    op = ins[31:26]; s = ins[25:21]; t = ins[20:16]; d = ins[15:11];
    sh = ins[10:6]; f = ins[5:0];
    se = {{16{ins[15]}}, ins[15:0]};
    a = m_reg[s]; b = m_reg[t];
    e_we = 1'b0; e_re = 1'b0; e_addr = a + se; e_wdata = b;
    mem_tag = "R6"; data_tag = m_tag[t];
    np = m_pc + 32'd4; pc_tag = "R2";
    case (op)
      6'b000000: case (f)
        6'b100001: wr(d, a + b, "R3");
        6'b100110: wr(d, a ^ b, "R3");
        6'b101010: wr(d, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0, "R3");
        6'b000000: wr(d, b << sh, "R3");
        default:   pc_tag = "R10";
      endcase
      6'b001001, 6'b001000: wr(t, a + se, "R4");
      6'b001010: wr(t, ($signed(a) < $signed(se)) ? 32'd1 : 32'd0, "R4");
      6'b100011: begin e_re = 1'b1; mem_tag = "R5"; wr(t, rdata, "R5"); end
      6'b101011: e_we = 1'b1;
      6'b000100: begin
        if (a == b) np = m_pc + 32'd4 + {se[29:0], 2'b00};
        pc_tag = "R7";
      end
      6'b000010: begin np = {np[31:28], ins[25:0], 2'b00}; pc_tag = "R8"; end
      default: pc_tag = "R10";
    endcase
    m_pc = np;
    m_reg[0] = 32'd0;
    m_tag[0] = "R9";
  endtask

  task automatic run(input logic [31:0] ins);
    logic [31:0] rdata;
    rdata = $urandom;
    check(pc_tag, imem_addr, m_pc);
    imem_data = ins;
    dmem_rdata = rdata;
    #1;
    model(ins, rdata);
    check({mem_tag, " store strobe"}, {31'd0, dmem_we}, {31'd0, e_we});
    check("R5 load strobe", {31'd0, dmem_re}, {31'd0, e_re});
    if (e_we || e_re) check({mem_tag, " address"}, dmem_addr, e_addr);
    if (e_we) check({"R6 store data via ", data_tag}, dmem_wdata, e_wdata);
    @(negedge clk);
  endtask

  function automatic int pick_reg();
    int k = $urandom % 8;
    if (k == 0) return 0;
    if (k == 7) return $urandom % 32;
    return k;
  endfunction

  task automatic rand_instr();
    int s = pick_reg(), t = pick_reg(), d = pick_reg();
    logic [15:0] im = 16'($urandom);
    case ($urandom % 14)
      0:  run(enc_r(s, t, d, 0, 6'b100001));
      1:  run(enc_r(s, t, d, 0, 6'b100110));
      2:  run(enc_r(s, t, d, 0, 6'b101010));
      3:  run(enc_r(0, t, d, $urandom % 32, 6'b000000));
      4:  run(enc_i(6'b001001, s, t, im));
      5:  run(enc_i(6'b001000, s, t, im));
      6:  run(enc_i(6'b001010, s, t, im));
      7:  run(enc_i(6'b100011, s, t, im));
      8, 9: run(enc_i(6'b101011, s, t, im));
      10: run(enc_i(6'b000100, s, ($urandom % 2) ? s : t, im));
      11: run({6'b000010, 26'($urandom)});
      12: run(enc_r(s, t, d, 0, 6'b111111));
      default: run(enc_i(6'b111111, s, t, im));
    endcase
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) begin m_reg[i] = 32'd0; m_tag[i] = "R9"; end
    imem_data = enc_i(6'b101011, 1, 2, 16'h10);
    dmem_rdata = 32'd0;
    #1;
    check("R1 store held off in reset", {31'd0, dmem_we}, 32'd0);
    @(negedge clk);
    imem_data = {6'b000010, 26'h3ff_ffff};
    repeat (2) @(negedge clk);
    check("R1 reset PC", imem_addr, 32'd0);
    rst = 1'b0;
    m_pc = 32'd0;
    pc_tag = "R1";

    for (int r = 1; r < 32; r++) run(enc_i(6'b001001, 0, r, 16'($urandom)));
    for (int r = 0; r < 32; r++) run(enc_i(6'b101011, 0, r, 16'(r * 4)));

    run(enc_i(6'b001001, 0, 1, 16'hffff));
    run(enc_r(0, 1, 1, 31, 6'b000000));
    run(enc_i(6'b001001, 1, 2, 16'hffff));
    run(enc_i(6'b001000, 2, 3, 16'h0001));
    run(enc_i(6'b001001, 1, 4, 16'h8000));
    run(enc_r(1, 2, 5, 0, 6'b101010));
    run(enc_r(2, 1, 6, 0, 6'b101010));
    run(enc_i(6'b001010, 1, 7, 16'h0000));
    run(enc_i(6'b001010, 2, 8, 16'hffff));
    run(enc_r(1, 2, 9, 0, 6'b100110));
    run(enc_i(6'b001001, 2, 0, 16'h1234));
    run(enc_r(1, 2, 0, 0, 6'b100001));
    run(enc_r(1, 1, 10, 0, 6'b000111));
    run(enc_i(6'b111011, 1, 11, 16'h5555));
    for (int r = 0; r < 12; r++) run(enc_i(6'b101011, 0, r, 16'h0));
    run(enc_i(6'b100011, 3, 12, 16'hfffc));
    run(enc_i(6'b101011, 12, 12, 16'h0008));
    run(enc_i(6'b000100, 1, 1, 16'h0010));
    run(enc_i(6'b000100, 1, 2, 16'h0010));
    run(enc_i(6'b000100, 0, 0, 16'hfff0));
    run({6'b000010, 26'h000_0040});
    run({6'b000010, 26'h3ff_fffe});
    run(enc_i(6'b000100, 0, 0, 16'h7fff));

    repeat (4000) rand_instr();
    for (int r = 0; r < 32; r++) run(enc_i(6'b101011, 0, r, 16'h0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule